// File: doc/BRIEF.md
# Multi-width Keccak permutation engine

This block applies the Keccak-f permutation, or its reduced-round Keccak-p form, to a 25-lane state held in registers. One datapath serves four state sizes: 200, 400, 800 and 1600 bits, which give lane widths of 8, 16, 32 and 64 bits. The engine performs one complete round per clock. Each round applies theta, then rho, then pi, then chi, then iota.

A host presents a state, a size code and an optional round count, and pulses a start input. The engine raises a busy flag while it iterates. It pulses done for one cycle when the last round has been applied. The result stays on the output until the next accepted start. Padding, absorbing, squeezing and any sponge or duplex sequencing belong to the logic around the engine.

Each lane sits in a 64-bit slot. Lane (x,y) occupies bits [64*(x+5y) +: 64] of the state buses. A lane narrower than 64 bits uses the low bits of its slot, and the bits above it are held at zero.

Top module: `kperm_core`

## Requirements
- R1: While reset is high and on the first cycle after it, busy_o and done_o are 0 and state_o is all zero.
- R2: A start_i seen while busy_o is 0 loads state_i and sets busy_o on the next cycle. At load, every bit of a slot above the selected lane width is cleared.
- R3: The engine applies one round per clock. done_o is high for exactly one cycle, n+1 cycles after the accepting edge, where n is the round count in effect. busy_o is 0 in that same cycle.
- R4: The size code width_sel_i selects the lane width: 0 gives 8 bits, 1 gives 16, 2 gives 32 and 3 gives 64. With rounds_i = 0 the engine runs the full count of 18, 20, 22 or 24 rounds for codes 0, 1, 2 and 3.
- R5: A rounds_i value from 1 up to the full count runs that many rounds, using the round constants of the last rounds of the full schedule. A value above the full count behaves as 0.
- R6: Each round is theta, rho (standard offsets mod w), pi ((x,y) to (y,2x+3y mod 5)), chi and iota. The iota constant is the standard 64-bit value truncated to w bits. Permuting an all-zero 1600-bit state over 24 rounds gives lane (0,0) = F1258F7940E1DDE7 (hex).
- R7: For lane widths below 64, the slot bits above the lane width on state_o stay zero while the engine runs and after it finishes.
- R8: A start_i seen while busy_o is 1 has no effect on the state progression, the round count or the timing of done_o.
- R9: A start_i presented in the cycle where done_o is high is accepted, and a new permutation begins.
- R10: While idle with no start, state_o holds its value whatever state_i does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to load a state and begin a permutation |
| width_sel_i | input | 2 | Lane width code (0:8, 1:16, 2:32, 3:64 bits) |
| rounds_i | input | 5 | Round count; 0 or above the full count means full |
| state_i | input | 1600 | State to load, 25 slots of 64 bits |
| state_o | output | 1600 | Current state, same layout |
| busy_o | output | 1 | Permutation in progress |
| done_o | output | 1 | One-cycle pulse after the last round |

## Verification
Two events can land on the same clock edge: the retirement of the final round, with done_o rising and busy_o falling, and the acceptance of a new start. The bench issues the next start in exactly the cycle where it sees done_o. It then checks that the finished result was visible in that cycle and that the new state is loaded and iterated with the new size and round count. A second collision, a start during a running permutation, is driven mid-run with different data. The engine must ignore it, and the per-cycle reference model compares every lane on each clock to confirm this.

// File: rtl/kperm_pkg.sv
package kperm_pkg;

    localparam int LANES  = 25;
    localparam int SLOT_W = 64;
    localparam int NR_MAX = 24;
    localparam int RIDX_W = $clog2(NR_MAX);
    localparam int ROT_W  = $clog2(SLOT_W);
    localparam int STATE_W = LANES * SLOT_W;

    typedef enum logic [1:0] {
        LW8  = 2'd0,
        LW16 = 2'd1,
        LW32 = 2'd2,
        LW64 = 2'd3
    } wsel_e;

    typedef logic [SLOT_W-1:0] lane_t;
    typedef logic [LANES-1:0][SLOT_W-1:0] state_t;
    typedef logic [RIDX_W-1:0] ridx_t;

    function automatic logic [ROT_W:0] lane_width(wsel_e ws);
        return (ROT_W+1)'(8) << ws;
    endfunction

    function automatic lane_t lane_mask(wsel_e ws);
        if (ws == LW64) return '1;
        return (lane_t'(1) << lane_width(ws)) - lane_t'(1);
    endfunction

    function automatic ridx_t full_rounds(wsel_e ws);
        return ridx_t'(18) + ridx_t'({ws, 1'b0});
    endfunction

    function automatic lane_t rotl_lane(lane_t v, logic [ROT_W-1:0] s, wsel_e ws);
        logic [ROT_W:0]   w;
        logic [ROT_W-1:0] sh;
        lane_t            r;
        w  = lane_width(ws);
        sh = s & ROT_W'(w - 1);
        r  = (v << sh) | (v >> (w - {1'b0, sh}));
        return r & lane_mask(ws);
    endfunction

    // Elaboration-time table of round constants from the degree-8 LFSR.
    function automatic logic [NR_MAX-1:0][SLOT_W-1:0] build_rc();
        logic [NR_MAX-1:0][SLOT_W-1:0] t;
        logic [7:0] r;
        t = '0;
        r = 8'h01;
        for (int i = 0; i < NR_MAX; i++) begin
            for (int j = 0; j < 7; j++) begin
                if (r[0]) t[i][(1 << j) - 1] = 1'b1;
                r = r[7] ? ({r[6:0], 1'b0} ^ 8'h71) : {r[6:0], 1'b0};
            end
        end
        return t;
    endfunction

    // Rotation offsets per lane slot (x + 5y), generated by walking the pi cycle.
    function automatic logic [LANES-1:0][ROT_W-1:0] build_rho();
        logic [LANES-1:0][ROT_W-1:0] o;
        int x, y, nx;
        o = '0;
        x = 1;
        y = 0;
        for (int t = 0; t < 24; t++) begin
            o[x + 5*y] = ROT_W'(((t + 1) * (t + 2) / 2) % SLOT_W);
            nx = y;
            y  = (2*x + 3*y) % 5;
            x  = nx;
        end
        return o;
    endfunction

endpackage

// File: rtl/kperm_round.sv
module kperm_round
    import kperm_pkg::*;
(
    input  state_t a_i,
    input  wsel_e  ws_i,
    input  lane_t  rc_i,
    output state_t y_o
);
    localparam logic [LANES-1:0][ROT_W-1:0] RHO = build_rho();

    lane_t  col [5];
    lane_t  dlt [5];
    state_t th;
    state_t pb;

    genvar gx, gy;
    generate
        for (gx = 0; gx < 5; gx++) begin : g_col
            assign col[gx] = a_i[gx] ^ a_i[gx+5] ^ a_i[gx+10] ^ a_i[gx+15] ^ a_i[gx+20];
        end
        for (gx = 0; gx < 5; gx++) begin : g_dlt
            assign dlt[gx] = col[(gx+4)%5] ^ rotl_lane(col[(gx+1)%5], ROT_W'(1), ws_i);
        end
        for (gx = 0; gx < 5; gx++) begin : g_x
            for (gy = 0; gy < 5; gy++) begin : g_y
                assign th[gx+5*gy] = a_i[gx+5*gy] ^ dlt[gx];
                assign pb[gy+5*((2*gx+3*gy)%5)] =
                    rotl_lane(th[gx+5*gy], RHO[gx+5*gy], ws_i);
                if (gx == 0 && gy == 0) begin : g_iota
                    assign y_o[0] = pb[0] ^ (~pb[1] & pb[2]) ^ (rc_i & lane_mask(ws_i));
                end else begin : g_chi
                    assign y_o[gx+5*gy] = pb[gx+5*gy]
                        ^ (~pb[((gx+1)%5)+5*gy] & pb[((gx+2)%5)+5*gy]);
                end
            end
        end
    endgenerate
endmodule

// File: rtl/kperm_ctrl.sv
module kperm_ctrl
    import kperm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  wsel_e      ws_i,
    input  logic [4:0] rounds_i,
    output logic       load_o,
    output logic       step_o,
    output ridx_t      ridx_o,
    output wsel_e      ws_q_o,
    output logic       busy_o,
    output logic       done_o
);
    ridx_t last_q;
    ridx_t nr_full;
    ridx_t first_idx;

    always_comb begin
        nr_full = full_rounds(ws_i);
        if (rounds_i == 5'd0 || rounds_i > 5'(nr_full))
            first_idx = '0;
        else
            first_idx = nr_full - ridx_t'(rounds_i);
    end

    assign load_o = start_i && !busy_o;
    assign step_o = busy_o;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_o <= 1'b0;
            done_o <= 1'b0;
            ridx_o <= '0;
            last_q <= '0;
            ws_q_o <= LW8;
        end else begin
            done_o <= 1'b0;
            if (busy_o) begin
                if (ridx_o == last_q) begin
                    busy_o <= 1'b0;
                    done_o <= 1'b1;
                end else begin
                    ridx_o <= ridx_o + ridx_t'(1);
                end
            end else if (start_i) begin
                busy_o <= 1'b1;
                ridx_o <= first_idx;
                last_q <= nr_full - ridx_t'(1);
                ws_q_o <= ws_i;
            end
        end
    end
endmodule

// File: rtl/kperm_core.sv
module kperm_core
    import kperm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start_i,
    input  logic [1:0]           width_sel_i,
    input  logic [4:0]           rounds_i,
    input  logic [STATE_W-1:0]   state_i,
    output logic [STATE_W-1:0]   state_o,
    output logic                 busy_o,
    output logic                 done_o
);
    localparam logic [NR_MAX-1:0][SLOT_W-1:0] RC_TAB = build_rc();

    wsel_e  ws_in;
    wsel_e  ws_q;
    logic   load;
    logic   step;
    ridx_t  ridx;
    state_t st_q;
    state_t st_in;
    state_t st_load;
    state_t st_next;
    lane_t  rc_cur;

    assign ws_in  = wsel_e'(width_sel_i);
    assign st_in  = state_t'(state_i);
    assign rc_cur = RC_TAB[ridx];

    genvar gi;
    generate
        for (gi = 0; gi < LANES; gi++) begin : g_mask
            assign st_load[gi] = st_in[gi] & lane_mask(ws_in);
        end
    endgenerate

    kperm_ctrl ctrl_i (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .ws_i     (ws_in),
        .rounds_i (rounds_i),
        .load_o   (load),
        .step_o   (step),
        .ridx_o   (ridx),
        .ws_q_o   (ws_q),
        .busy_o   (busy_o),
        .done_o   (done_o)
    );

    kperm_round round_i (
        .a_i  (st_q),
        .ws_i (ws_q),
        .rc_i (rc_cur),
        .y_o  (st_next)
    );

    always_ff @(posedge clk) begin
        if (rst)       st_q <= '0;
        else if (step) st_q <= st_next;
        else if (load) st_q <= st_load;
    end

    assign state_o = STATE_W'(st_q);
endmodule

// File: rtl/kperm_chk.sv
module kperm_chk
    import kperm_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               start_i,
    input logic               busy_o,
    input logic               done_o,
    input logic [STATE_W-1:0] state_o,
    input wsel_e              ws_q
);
    logic [STATE_W-1:0] fmask;
    always_comb begin
        for (int i = 0; i < LANES; i++) fmask[i*SLOT_W +: SLOT_W] = lane_mask(ws_q);
    end

    p_reset_idle_r1: assert property (@(posedge clk) rst |=> (!busy_o && !done_o));

    p_accept_r2: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> busy_o);

    p_done_single_r3: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    p_done_ends_busy_r3: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!busy_o && $past(busy_o)));

    p_upper_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (busy_o || done_o) |-> ((state_o & ~fmask) == '0));

    p_busy_start_r8: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !done_o && start_i) |=> (busy_o || done_o));

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !start_i) |=> $stable(state_o));
endmodule

bind kperm_core kperm_chk chk_i (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .state_o (state_o),
    .ws_q    (ws_q)
);

// File: tb/kperm_core_tb_top.sv
module kperm_core_tb_top;
    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [1:0]    width_sel = 2'd0;
    logic [4:0]    rounds = 5'd0;
    logic [1599:0] state_in = '0;
    logic [1599:0] state_o;
    logic          busy_o, done_o;

    int    n_checks = 0;
    int    n_fail   = 0;
    string cur_tag  = "R1";
    logic [63:0] seed = 64'h9E3779B97F4A7C15;

    always #4 clk = ~clk;

    kperm_core dut_i (
        .clk(clk), .rst(rst), .start_i(start), .width_sel_i(width_sel),
        .rounds_i(rounds), .state_i(state_in), .state_o(state_o),
        .busy_o(busy_o), .done_o(done_o)
    );

    // ---------------- reference model ----------------
    int rho_tab [25] = '{0, 1, 62, 28, 27, 36, 44, 6, 55, 20, 3, 10, 43, 25, 39,
                         41, 45, 15, 21, 8, 18, 2, 61, 56, 14};
    logic [63:0] m_rc [24];
    logic [63:0] m_st [25];
    bit m_busy, m_done;
    int m_idx, m_last, m_w;

    function automatic bit rc_bit(int t);
        logic [8:0] r = 9'd1;
        for (int i = 0; i < t % 255; i++) begin
            r = r << 1;
            if (r[8]) r = r ^ 9'h171;
        end
        return r[0];
    endfunction

    function automatic logic [63:0] wmask(int w);
        return (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
    endfunction

    function automatic logic [63:0] mrot(logic [63:0] v, int s, int w);
        int k = s % w;
        if (k == 0) return v;
        return ((v << k) | (v >> (w - k))) & wmask(w);
    endfunction

    task automatic model_round(int ri);
        logic [63:0] c [5];
        logic [63:0] d [5];
        logic [63:0] b [25];
        for (int x = 0; x < 5; x++)
            c[x] = m_st[x] ^ m_st[x+5] ^ m_st[x+10] ^ m_st[x+15] ^ m_st[x+20];
        for (int x = 0; x < 5; x++)
            d[x] = c[(x+4)%5] ^ mrot(c[(x+1)%5], 1, m_w);
        for (int x = 0; x < 5; x++)
            for (int y = 0; y < 5; y++)
                b[y + 5*((2*x+3*y)%5)] = mrot(m_st[x+5*y] ^ d[x], rho_tab[x+5*y], m_w);
        for (int y = 0; y < 5; y++)
            for (int x = 0; x < 5; x++)
                m_st[x+5*y] = b[x+5*y] ^ (~b[(x+1)%5+5*y] & b[(x+2)%5+5*y]);
        m_st[0] = m_st[0] ^ (m_rc[ri] & wmask(m_w));
    endtask

    initial begin
        for (int i = 0; i < 24; i++) begin
            m_rc[i] = '0;
            for (int j = 0; j < 7; j++)
                if (rc_bit(j + 7*i)) m_rc[i][(1 << j) - 1] = 1'b1;
        end
    end

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_done = 0;
            for (int i = 0; i < 25; i++) m_st[i] = '0;
        end else begin
            m_done = 0;
            if (m_busy) begin
                model_round(m_idx);
                if (m_idx == m_last) begin m_busy = 0; m_done = 1; end
                else m_idx++;
            end else if (start) begin
                int full, n;
                m_w  = 8 << width_sel;
                full = 18 + 2*int'(width_sel);
                n    = (rounds == 0 || int'(rounds) > full) ? full : int'(rounds);
                m_idx = full - n; m_last = full - 1; m_busy = 1;
                for (int i = 0; i < 25; i++)
                    m_st[i] = state_in[i*64 +: 64] & wmask(m_w);
            end
        end
    end

    // ---------------- checking ----------------
    task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if ($time > 0) begin
            int bad = -1;
            for (int i = 0; i < 25; i++)
                if (bad < 0 && state_o[i*64 +: 64] !== m_st[i]) bad = i;
            chk(busy_o === m_busy, cur_tag, "busy per cycle", 64'(busy_o), 64'(m_busy));
            chk(done_o === m_done, cur_tag, "done per cycle", 64'(done_o), 64'(m_done));
            if (bad >= 0)
                chk(1'b0, cur_tag, $sformatf("lane %0d per cycle", bad),
                    state_o[bad*64 +: 64], m_st[bad]);
            else
                chk(1'b1, cur_tag, "state per cycle", '0, '0);
        end
    end

    function automatic logic [63:0] nxt();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 7);
        seed = seed ^ (seed << 17);
        return seed;
    endfunction

    function automatic logic [1599:0] rand_state();
        logic [1599:0] v;
        for (int i = 0; i < 25; i++) v[i*64 +: 64] = nxt();
        return v;
    endfunction

    // Called at a negedge; returns at the negedge where done_o is seen.
    task automatic run_perm(int ws, int nreq, logic [1599:0] data, string tag, int inj);
        int full, n, cnt;
        full = 18 + 2*ws;
        n = (nreq == 0 || nreq > full) ? full : nreq;
        cur_tag = tag;
        width_sel = 2'(ws); rounds = 5'(nreq); state_in = data; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cnt = 1;
        chk(busy_o === 1'b1, "R2", "busy after accepted start", 64'(busy_o), 64'd1);
        while (done_o !== 1'b1) begin
            if (inj > 0 && cnt == inj) begin
                start = 1'b1; state_in = rand_state();
                width_sel = 2'(3 - ws); rounds = 5'd1;
            end else if (inj > 0 && cnt == inj + 1) begin
                start = 1'b0;
            end
            @(negedge clk);
            cnt++;
        end
        start = 1'b0;
        chk(cnt == n + 1, tag, "cycles start to done", 64'(cnt), 64'(n + 1));
        chk(busy_o === 1'b0, "R3", "busy low with done", 64'(busy_o), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(busy_o === 1'b0 && done_o === 1'b0, "R1", "flags in reset",
            64'({busy_o, done_o}), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(state_o === '0, "R1", "state after reset", state_o[63:0], 64'd0);

        run_perm(3, 0, '0, "R6", 0);
        chk(state_o[63:0] === 64'hF1258F7940E1DDE7, "R6", "zero-state known answer",
            state_o[63:0], 64'hF1258F7940E1DDE7);

        run_perm(3, 0, rand_state(), "R4", 0);
        run_perm(2, 0, rand_state(), "R4", 0);
        run_perm(1, 0, rand_state(), "R4", 0);
        run_perm(0, 0, rand_state(), "R4", 0);

        run_perm(3, 12, rand_state(), "R5", 0);
        run_perm(2, 1, rand_state(), "R5", 0);
        run_perm(1, 31, rand_state(), "R5", 0);
        run_perm(0, 5, rand_state(), "R5", 0);

        run_perm(0, 0, {1600{1'b1}}, "R7", 0);
        begin
            logic [1599:0] up = '0;
            for (int i = 0; i < 25; i++) up[i*64 +: 64] = state_o[i*64 +: 64] & ~wmask(8);
            chk(up === '0, "R7", "upper slot bits after 8-bit run", up[63:0], 64'd0);
        end

        run_perm(3, 0, rand_state(), "R8", 4);
        run_perm(1, 3, rand_state(), "R8", 2);

        // Start issued in the done cycle of the previous run.
        run_perm(2, 0, rand_state(), "R9", 0);
        run_perm(0, 3, rand_state(), "R9", 0);
        run_perm(3, 2, rand_state(), "R9", 0);

        begin
            logic [1599:0] held;
            @(negedge clk);
            cur_tag = "R10";
            held = state_o;
            for (int k = 0; k < 6; k++) begin
                state_in = rand_state(); width_sel = 2'(k % 4);
                @(negedge clk);
            end
            chk(state_o === held, "R10", "idle hold", state_o[63:0], held[63:0]);
        end

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule